// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block receives asynchronous serial frames on one input line. Each frame has one start bit, eight data bits and one stop bit, with no parity. It hands each received byte to a consumer through a valid/ready handshake. A sampling tick at sixteen times the bit rate is produced internally. Its divider is derived from a clock-frequency parameter and a bit-rate parameter. The line passes through a two-flop synchronizer before it is sampled.

Each bit is judged by a two-out-of-three vote. The three readings are taken on oversample ticks 7, 8 and 9 of the bit. A falling edge on an idle line opens a frame. The start bit is checked again by the vote, and if it reads high the block treats the edge as noise and goes back to idle.

The shifting register and the output holding register are separate. A new frame can therefore arrive while the previous byte still waits for the consumer. Two sticky flags report problems and stay set until reset:
- the frame-error flag, set when a stop bit is read low;
- the overrun flag, set when a frame completes while the held byte is still unacknowledged.

Top module: `uart_rx_vote`

## Requirements
- R1: A synchronous active-low reset clears `byte_valid`, `frame_err` and `overrun_err`, and sets `byte_data` to 0.
- R2: A frame made of a low start bit, eight data bits sent least-significant bit first, and a high stop bit is presented on `byte_data` with `byte_valid` high.
- R3: One bit lasts 16 sampling ticks, and one tick is CLK_HZ/(BAUD*16) clock cycles. `byte_valid` rises during the stop bit, between 610 and 625 clock cycles after the start edge, for the bench setting of 4 clocks per tick.
- R4: A disturbance on the line lasting one tick period inside a data bit does not change that bit's value, because each bit is a majority of three readings.
- R5: A low pulse on the idle line that is shorter than half a bit is rejected as a false start. No byte results, and the next frame is received correctly.
- R6: `byte_valid` stays high with `byte_data` unchanged until `byte_ready` is sampled high, and it is low on the cycle after that. A frame can be shifted in while the previous byte is held, and it loads if that byte was acknowledged before the new frame completed.
- R7: If a valid frame completes while `byte_valid` is high and `byte_ready` is low, `overrun_err` is set, the held byte is kept and the new byte is dropped.
- R8: A frame whose stop bit reads low sets `frame_err` and presents no byte.
- R9: `frame_err` and `overrun_err` stay set until reset, even after later good frames.
- R10: While `en` is low, line activity is ignored and no byte is produced. Reception resumes when `en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Reception enable; low holds the receiver idle |
| rx_line | input | 1 | Serial line, idles high |
| byte_ready | input | 1 | Consumer has taken the held byte |
| byte_data | output | 8 | Held received byte |
| byte_valid | output | 1 | `byte_data` holds an unread byte |
| frame_err | output | 1 | Sticky: a stop bit was read low |
| overrun_err | output | 1 | Sticky: a byte was dropped because the held one was unread |

## Verification
Two situations are hard to reach from the ports: a tick-long glitch that corrupts exactly one of the three votes, and a second frame finishing against an unacknowledged byte.

- **Single-vote glitch.** The bench inverts the line for exactly four clocks near the middle of a data bit. With a four-clock tick, that window contains exactly one sampling tick, whatever the receiver's tick phase is.
- **Collision with a held byte.** The bench turns off automatic acknowledgement, so the consumer holds a byte back. One frame is run concurrently with a delayed acknowledge, which exercises the double buffer. A second frame is run with no acknowledge, which forces an overrun.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and helpers for the oversampling receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // Two-out-of-three majority of line readings.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_tick.sv
// Module: oversample tick divider.
// Emits a one-cycle pulse every CLK_HZ/(BAUD*OVS) clocks while enabled.
// Assumes: CLK_HZ >= BAUD*OVS; a quotient below 1 is raised to 1 (tick every clock).
module uart_rx_tick #(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200,
    parameter int OVS    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int DIV_RAW = CLK_HZ / (BAUD * OVS);
    localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int CW      = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every_clk
            assign tick = en;
        end else begin : g_counter
            logic [CW-1:0] cnt;

            // Count clocks between ticks; held at zero while disabled.
            always_ff @(posedge clk) begin
                if (!rst_n || !en)
                    cnt <= '0;
                else if (cnt == CW'(DIV - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign tick = en && (cnt == CW'(DIV - 1));

            // R3
            div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt <= CW'(DIV - 1));
            // R3
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/uart_rx_sync.sv
// Module: multi-flop synchronizer for the asynchronous serial line.
// Assumes: the line idles high, so the flops reset to one.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe <= '1;
        else
            pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
// Module: frame sequencer with majority sampling.
// Detects a start edge, votes each bit on oversample ticks MID-1, MID and MID+1,
// shifts data least-significant bit first, and pulses done with the byte and the
// stop-bit verdict at the third stop-bit sample.
// Assumes: line is already synchronized; OVS >= 4 and even.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          line,
    output logic          done,
    output logic [DW-1:0] done_data,
    output logic          done_stop_ok
);
    localparam int OCW  = $clog2(OVS);
    localparam int BCW  = (DW > 1) ? $clog2(DW) : 1;
    localparam int MID  = OVS / 2;
    localparam int LAST = OVS - 1;

    rx_state_t      state;
    logic [OCW-1:0] oscnt;
    logic [BCW-1:0] bitcnt;
    logic           samp_a;
    logic           samp_b;
    logic           prev_line;
    logic [DW-1:0]  shreg;
    logic           maj;

    assign maj = vote3(samp_a, samp_b, line);

    // Sequence one frame per start edge, voting each bit on three middle ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state        <= RX_IDLE;
            oscnt        <= '0;
            bitcnt       <= '0;
            samp_a       <= 1'b1;
            samp_b       <= 1'b1;
            prev_line    <= 1'b1;
            shreg        <= '0;
            done         <= 1'b0;
            done_data    <= '0;
            done_stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev_line <= line;
                if (state == RX_IDLE) begin
                    if (prev_line && !line) begin
                        state  <= RX_START;
                        oscnt  <= '0;
                        bitcnt <= '0;
                    end
                end else begin
                    oscnt <= (oscnt == OCW'(LAST)) ? '0 : oscnt + 1'b1;
                    if (oscnt == OCW'(MID - 1))
                        samp_a <= line;
                    if (oscnt == OCW'(MID))
                        samp_b <= line;
                    if (oscnt == OCW'(MID + 1)) begin
                        unique case (state)
                            RX_START: if (maj) state <= RX_IDLE;
                            RX_DATA:  shreg <= {maj, shreg[DW-1:1]};
                            RX_STOP: begin
                                done         <= 1'b1;
                                done_data    <= shreg;
                                done_stop_ok <= maj;
                                state        <= RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (oscnt == OCW'(LAST)) begin
                        if (state == RX_START)
                            state <= RX_DATA;
                        else if (state == RX_DATA) begin
                            if (bitcnt == BCW'(DW - 1))
                                state <= RX_STOP;
                            else
                                bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        done |-> state == RX_IDLE && $past(state) == RX_STOP);
    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == RX_IDLE && !done);
    // R5
    idle_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && tick && !(prev_line && !line)) |=> state == RX_IDLE);

endmodule

// File: rtl/uart_rx_vote.sv
// Module: top of the oversampling serial receiver.
// Chains synchronizer, tick divider and frame sequencer, and owns the output
// holding register, its valid/ready handshake and the sticky error flags.
// Assumes: 8N1 frames; the consumer acknowledges with byte_ready while byte_valid is high.
module uart_rx_vote #(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200,
    parameter int OVS    = 16,
    parameter int DW     = 8,
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rx_line,
    input  logic          byte_ready,
    output logic [DW-1:0] byte_data,
    output logic          byte_valid,
    output logic          frame_err,
    output logic          overrun_err
);
    logic          line_s;
    logic          tick;
    logic          rx_done;
    logic [DW-1:0] rx_data;
    logic          rx_stop_ok;

    uart_rx_sync #(.STAGES(SYNC_N)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    uart_rx_tick #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .tick (tick)
    );

    uart_rx_frame #(.OVS(OVS), .DW(DW)) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .tick        (tick),
        .line        (line_s),
        .done        (rx_done),
        .done_data   (rx_data),
        .done_stop_ok(rx_stop_ok)
    );

    // Load finished bytes into the holding register and keep the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_data   <= '0;
            byte_valid  <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            if (byte_valid && byte_ready)
                byte_valid <= 1'b0;
            if (rx_done) begin
                if (!rx_stop_ok)
                    frame_err <= 1'b1;
                else if (byte_valid && !byte_ready)
                    overrun_err <= 1'b1;
                else begin
                    byte_data  <= rx_data;
                    byte_valid <= 1'b1;
                end
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !byte_valid && !frame_err && !overrun_err && byte_data == '0);
    // R6
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));
    // R6
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_ready && !rx_done |=> !byte_valid);
    // R7
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready && rx_done |=> byte_valid && $stable(byte_data));
    // R8
    ferr_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !rx_stop_ok |=> frame_err && $stable(byte_data));
    // R9
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |=> overrun_err);

endmodule

// File: tb/uart_rx_vote_tb_top.sv
// Bench: scoreboard for the oversampling receiver. A driver task serializes
// frames and queues the bytes it expects; a monitor pops and compares them as
// byte_valid appears and acknowledges each one.
module uart_rx_vote_tb_top;
    localparam int CLK_HZ = 1_600_000;
    localparam int BAUD   = 25_000;
    localparam int TPB    = 4;          // clocks per tick
    localparam int BITC   = 16 * TPB;   // clocks per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       rx_line = 1'b1;
    logic       byte_ready = 1'b0;
    logic [7:0] byte_data;
    logic       byte_valid;
    logic       frame_err;
    logic       overrun_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit auto_ack = 1;
    bit ack_req = 0;
    bit ack_pulse = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    uart_rx_vote #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .rx_line    (rx_line),
        .byte_ready (byte_ready),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .frame_err  (frame_err),
        .overrun_err(overrun_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: serialize one frame; glitch_bit >= 0 inverts one tick mid-bit.
    task automatic send_frame(input logic [7:0] d, input logic stop_v,
                              input bit expect_it, input int glitch_bit);
        if (expect_it) exp_q.push_back(d);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            if (i == glitch_bit) begin
                repeat (34) @(negedge clk);
                rx_line = ~d[i];
                repeat (TPB) @(negedge clk);
                rx_line = d[i];
                repeat (BITC - 34 - TPB) @(negedge clk);
            end else
                repeat (BITC) @(negedge clk);
        end
        rx_line = stop_v;
        repeat (BITC) @(negedge clk);
        rx_line = 1'b1;
        repeat (BITC / 4) @(negedge clk);
    endtask

    // Monitor: compare delivered bytes against the queue and drive the acknowledge.
    always @(negedge clk) begin
        if (ack_pulse) begin
            byte_ready = 1'b0;
            ack_pulse = 0;
            check(!byte_valid, "R6 valid low after ready", byte_valid, 0);
        end else if (rst_n && byte_valid && (auto_ack || ack_req)) begin
            if (auto_ack) begin
                if (exp_q.size() == 0)
                    check(0, "R2 unexpected byte", byte_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(byte_data == e, "R2 byte value", byte_data, e);
                end
            end
            ack_req = 0;
            byte_ready = 1'b1;
            ack_pulse = 1;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!byte_valid && !frame_err && !overrun_err && byte_data == 8'h00,
              "R1 reset state", {byte_valid, frame_err, overrun_err, byte_data}, 0);

        // R2 several patterns
        send_frame(8'hA5, 1, 1, -1);
        send_frame(8'h3C, 1, 1, -1);
        send_frame(8'h00, 1, 1, -1);
        send_frame(8'hFF, 1, 1, -1);
        send_frame(8'h81, 1, 1, -1);

        // R4 single-tick glitches at different bits
        send_frame(8'h5A, 1, 1, 0);
        send_frame(8'hC3, 1, 1, 3);
        send_frame(8'h0F, 1, 1, 7);

        // R5 false start then a real frame
        @(negedge clk);
        rx_line = 1'b0;
        repeat (2 * TPB) @(negedge clk);
        rx_line = 1'b1;
        repeat (BITC) @(negedge clk);
        check(!byte_valid && exp_q.size() == 0, "R5 no byte from glitch", byte_valid, 0);
        send_frame(8'h6B, 1, 1, -1);
        check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

        // R3 latency from start edge to valid
        auto_ack = 0;
        fork
            send_frame(8'h2D, 1, 0, -1);
            begin
                t = 0;
                while (!byte_valid && t < 2000) begin
                    @(negedge clk);
                    t++;
                end
                check(t >= 610 && t <= 625, "R3 valid timing", t, 617);
            end
        join
        check(byte_valid && byte_data == 8'h2D, "R3 byte", byte_data, 8'h2D);
        ack_req = 1;
        repeat (4) @(negedge clk);

        // R6 double buffer: hold one byte while the next shifts in
        send_frame(8'h11, 1, 0, -1);
        check(byte_valid && byte_data == 8'h11, "R6 first held", byte_data, 8'h11);
        fork
            send_frame(8'h22, 1, 0, -1);
            begin
                repeat (300) @(negedge clk);
                check(byte_valid && byte_data == 8'h11, "R6 still held", byte_data, 8'h11);
                ack_req = 1;
            end
        join
        check(byte_valid && byte_data == 8'h22 && !overrun_err, "R6 second loaded",
              byte_data, 8'h22);
        ack_req = 1;
        repeat (4) @(negedge clk);

        // R7 overrun keeps the held byte
        send_frame(8'h33, 1, 0, -1);
        send_frame(8'h44, 1, 0, -1);
        check(overrun_err, "R7 overrun set", overrun_err, 1);
        check(byte_valid && byte_data == 8'h33, "R7 old byte kept", byte_data, 8'h33);
        ack_req = 1;
        repeat (4) @(negedge clk);

        // R8 bad stop bit
        auto_ack = 1;
        send_frame(8'h55, 0, 0, -1);
        check(frame_err, "R8 frame error set", frame_err, 1);
        check(!byte_valid, "R8 no byte", byte_valid, 0);

        // R9 flags sticky across a good frame
        send_frame(8'h66, 1, 1, -1);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R9 good frame delivered", exp_q.size(), 0);
        check(frame_err && overrun_err, "R9 flags sticky", {frame_err, overrun_err}, 3);

        // R10 disabled receiver ignores the line
        en = 1'b0;
        send_frame(8'h77, 1, 0, -1);
        check(!byte_valid, "R10 ignored while disabled", byte_valid, 0);
        en = 1'b1;
        repeat (BITC) @(negedge clk);
        send_frame(8'h78, 1, 1, -1);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R10 resumes", exp_q.size(), 0);

        // R1 reset clears sticky flags
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!frame_err && !overrun_err && !byte_valid && byte_data == 8'h00,
              "R1 flags cleared", {frame_err, overrun_err, byte_valid}, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule